// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Logic

This block raises and clears doorbell interrupts between the two ports of a shared memory. Each port presents a chip-enable pair, a read/write select, active-low byte enables and an address. The two highest addresses of the memory act as mailboxes: the top address belongs to the right port and the address one below it belongs to the left port.

When one port writes the other port's mailbox, the other port's interrupt is raised. The interrupt stays raised until its owner reads its own mailbox. Both interrupt flags are active low and come from registers. They change on the clock edge that samples the qualifying access. An active-low master reset, which may be asserted asynchronously, drops both requests.

Top module: `mbox_irq`

## Requirements
- R1: While `rst_n` is low, both `l_int_n` and `r_int_n` are high (deasserted), including after reset is reapplied mid-operation.
- R2: A left write (`l_rw`=0, port enabled) to address 2^AW-1 with at least one `l_be_n` bit low drives `r_int_n` low after that clock edge.
- R3: A right read (`r_rw`=1, port enabled) of address 2^AW-1 drives `r_int_n` high after that edge. Byte enables are not considered for reads.
- R4: A right write to address 2^AW-2 with at least one `r_be_n` bit low drives `l_int_n` low after that edge.
- R5: A left read of address 2^AW-2 drives `l_int_n` high after that edge.
- R6: A write whose byte enables are all high (all inactive) sets no interrupt.
- R7: A port is enabled only when its `*_ce0_n` is 0 and its `*_ce1` is 1. Any other combination makes its access neither set nor clear anything.
- R8: If a flag is set and cleared in the same cycle, it ends up set (low).
- R9: Accesses to other addresses change nothing. A port's read of the opposite port's mailbox changes nothing. A port's write to its own mailbox changes nothing.
- R10: With no qualifying access, both flags keep their value from one cycle to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Active-low master reset, asynchronous assert |
| l_ce0_n | input | 1 | Left chip enable, active low |
| l_ce1 | input | 1 | Left chip enable, active high |
| l_rw | input | 1 | Left access type: 1 read, 0 write |
| l_be_n | input | BW | Left byte enables, active low |
| l_addr | input | AW | Left address |
| r_ce0_n | input | 1 | Right chip enable, active low |
| r_ce1 | input | 1 | Right chip enable, active high |
| r_rw | input | 1 | Right access type: 1 read, 0 write |
| r_be_n | input | BW | Right byte enables, active low |
| r_addr | input | AW | Right address |
| l_int_n | output | 1 | Interrupt to the left port, active low |
| r_int_n | output | 1 | Interrupt to the right port, active low |

## Verification
The hardest case to produce is a set and a clear of the same flag landing in one cycle. It needs the two ports to act together: the left port writes the right mailbox in the same cycle that the right port reads it. The driver task takes both ports' fields for every cycle, so the stimulus puts that pair on one clock edge. It then follows with a lone read to show the flag was held set and can still be cleared. Reapplying reset while both flags are set covers the reset path from a non-trivial state.

// File: rtl/mbox_irq.sv
module mbox_irq #(
  parameter int AW = 20,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          l_ce0_n,
  input  logic          l_ce1,
  input  logic          l_rw,
  input  logic [BW-1:0] l_be_n,
  input  logic [AW-1:0] l_addr,
  input  logic          r_ce0_n,
  input  logic          r_ce1,
  input  logic          r_rw,
  input  logic [BW-1:0] r_be_n,
  input  logic [AW-1:0] r_addr,
  output logic          l_int_n,
  output logic          r_int_n
);
  localparam logic [AW-1:0] R_BOX = {AW{1'b1}};
  localparam logic [AW-1:0] L_BOX = {{(AW-1){1'b1}}, 1'b0};

  logic l_en, r_en, l_wr, r_wr;
  logic set_r, clr_r, set_l, clr_l;
  logic l_flag, r_flag;

  assign l_en = ~l_ce0_n & l_ce1;
  assign r_en = ~r_ce0_n & r_ce1;
  assign l_wr = l_en & ~l_rw & ~(&l_be_n);
  assign r_wr = r_en & ~r_rw & ~(&r_be_n);

  assign set_r = l_wr & (l_addr == R_BOX);
  assign clr_r = r_en & r_rw & (r_addr == R_BOX);
  assign set_l = r_wr & (r_addr == L_BOX);
  assign clr_l = l_en & l_rw & (l_addr == L_BOX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_flag <= 1'b0;
      r_flag <= 1'b0;
    end else begin
      if (set_r)      r_flag <= 1'b1;
      else if (clr_r) r_flag <= 1'b0;
      if (set_l)      l_flag <= 1'b1;
      else if (clr_l) l_flag <= 1'b0;
    end
  end

  assign l_int_n = ~l_flag;
  assign r_int_n = ~r_flag;
endmodule

// File: rtl/mbox_irq_chk.sv
module mbox_irq_chk #(
  parameter int AW = 20,
  parameter int BW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          l_ce0_n,
  input logic          l_ce1,
  input logic          l_rw,
  input logic [BW-1:0] l_be_n,
  input logic [AW-1:0] l_addr,
  input logic          r_ce0_n,
  input logic          r_ce1,
  input logic          r_rw,
  input logic [BW-1:0] r_be_n,
  input logic [AW-1:0] r_addr,
  input logic          l_int_n,
  input logic          r_int_n
);
  localparam logic [AW-1:0] TOP  = {AW{1'b1}};
  localparam logic [AW-1:0] NEXT = {{(AW-1){1'b1}}, 1'b0};

  logic lw_top, rr_top, rw_next, lr_next;
  assign lw_top  = !l_ce0_n && l_ce1 && !l_rw && (l_be_n != '1) && (l_addr == TOP);
  assign rr_top  = !r_ce0_n && r_ce1 && r_rw && (r_addr == TOP);
  assign rw_next = !r_ce0_n && r_ce1 && !r_rw && (r_be_n != '1) && (r_addr == NEXT);
  assign lr_next = !l_ce0_n && l_ce1 && l_rw && (l_addr == NEXT);

  assert_reset_idle_R1: assert property (@(posedge clk) !rst_n |-> (l_int_n && r_int_n));
  assert_right_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lw_top |=> !r_int_n);
  assert_right_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rr_top && !lw_top) |=> r_int_n);
  assert_left_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rw_next |=> !l_int_n);
  assert_left_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lr_next && !rw_next) |=> l_int_n);
  assert_no_byte_no_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (l_be_n == '1 && r_int_n) |=> r_int_n);
  assert_disabled_left_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!(!l_ce0_n && l_ce1) && r_int_n) |=> r_int_n);
  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (lw_top && rr_top) |=> !r_int_n);
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!lw_top && !rr_top && !rw_next && !lr_next && $past(rst_n))
      |=> ($stable(l_int_n) && $stable(r_int_n)));
endmodule

bind mbox_irq mbox_irq_chk #(.AW(AW), .BW(BW)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .l_ce0_n(l_ce0_n), .l_ce1(l_ce1), .l_rw(l_rw), .l_be_n(l_be_n), .l_addr(l_addr),
  .r_ce0_n(r_ce0_n), .r_ce1(r_ce1), .r_rw(r_rw), .r_be_n(r_be_n), .r_addr(r_addr),
  .l_int_n(l_int_n), .r_int_n(r_int_n)
);

// File: tb/mbox_irq_tb.sv
`timescale 1ns/1ps
module mbox_irq_tb;
  localparam int AW = 20;
  localparam int BW = 8;
  localparam logic [AW-1:0] TOP  = {AW{1'b1}};
  localparam logic [AW-1:0] NEXT = TOP - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic l_ce0_n = 1'b1, l_ce1 = 1'b0, l_rw = 1'b1;
  logic r_ce0_n = 1'b1, r_ce1 = 1'b0, r_rw = 1'b1;
  logic [BW-1:0] l_be_n = '1, r_be_n = '1;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic l_int_n, r_int_n;

  always #2.5 clk = ~clk;

  mbox_irq #(.AW(AW), .BW(BW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .l_ce0_n(l_ce0_n), .l_ce1(l_ce1), .l_rw(l_rw), .l_be_n(l_be_n), .l_addr(l_addr),
    .r_ce0_n(r_ce0_n), .r_ce1(r_ce1), .r_rw(r_rw), .r_be_n(r_be_n), .r_addr(r_addr),
    .l_int_n(l_int_n), .r_int_n(r_int_n)
  );

  typedef struct { logic l; logic r; string tag; } exp_t;
  exp_t q[$];
  int checks = 0, fails = 0;
  logic m_l = 1'b0, m_r = 1'b0;
  bit done = 1'b0;

  task automatic drive(input logic le0, le1, lrw, input logic [BW-1:0] lbe, input logic [AW-1:0] la,
                       input logic re0, re1, rrw, input logic [BW-1:0] rbe, input logic [AW-1:0] ra,
                       input logic rst, input string tag);
    logic lce, rce, sr, cr, sl, cl;
    exp_t e;
    @(negedge clk);
    l_ce0_n = le0; l_ce1 = le1; l_rw = lrw; l_be_n = lbe; l_addr = la;
    r_ce0_n = re0; r_ce1 = re1; r_rw = rrw; r_be_n = rbe; r_addr = ra;
    rst_n = rst;
    lce = !le0 && le1;
    rce = !re0 && re1;
    sr = lce && !lrw && (lbe != '1) && (la == TOP);
    cr = rce && rrw && (ra == TOP);
    sl = rce && !rrw && (rbe != '1) && (ra == NEXT);
    cl = lce && lrw && (la == NEXT);
    if (!rst) begin m_l = 1'b0; m_r = 1'b0; end
    else begin
      if (sr) m_r = 1'b1; else if (cr) m_r = 1'b0;
      if (sl) m_l = 1'b1; else if (cl) m_l = 1'b0;
    end
    e.l = ~m_l; e.r = ~m_r; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(input string tag);
    drive(1, 0, 1, '1, '0, 1, 0, 1, '1, '0, 1'b1, tag);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (q.size() != 0) begin
        e = q.pop_front();
        checks++;
        if (l_int_n !== e.l || r_int_n !== e.r) begin
          fails++;
          $display("FAIL %s: l_int_n=%b r_int_n=%b expected %b %b", e.tag, l_int_n, r_int_n, e.l, e.r);
        end
      end
    end
  end

  initial begin : watchdog
    #(200000 * 5);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #1 rst_n = 1'b0;
    repeat (3) drive(1, 0, 1, '1, '0, 1, 0, 1, '1, '0, 1'b0, "R1 reset");
    idle("R10 after reset");
    drive(0, 1, 0, 8'hFE, TOP, 1, 0, 1, '1, '0, 1'b1, "R2 left writes right box");
    idle("R10 hold set");
    idle("R10 hold set");
    drive(0, 1, 1, '1, TOP, 1, 0, 1, '1, '0, 1'b1, "R9 left reads right box");
    drive(1, 0, 1, '1, '0, 0, 1, 0, 8'h00, TOP, 1'b1, "R9 right writes own box");
    drive(1, 0, 1, '1, '0, 0, 1, 1, '1, TOP - 5, 1'b1, "R9 right reads other addr");
    drive(1, 0, 1, '1, '0, 0, 1, 1, 8'h00, TOP, 1'b1, "R3 right reads own box");
    drive(1, 0, 1, '1, '0, 0, 1, 0, 8'h7F, NEXT, 1'b1, "R4 right writes left box");
    drive(0, 0, 1, '1, NEXT, 1, 0, 1, '1, '0, 1'b1, "R7 left ce1 low");
    drive(1, 1, 1, '1, NEXT, 1, 0, 1, '1, '0, 1'b1, "R7 left ce0_n high");
    drive(0, 1, 1, '1, TOP, 1, 0, 1, '1, '0, 1'b1, "R9 left reads right box");
    drive(0, 1, 1, '1, NEXT, 1, 0, 1, '1, '0, 1'b1, "R5 left reads own box");
    drive(0, 1, 0, '1, TOP, 1, 0, 1, '1, '0, 1'b1, "R6 write no byte enable");
    drive(1, 0, 0, 8'h00, TOP, 1, 0, 1, '1, '0, 1'b1, "R7 left disabled write");
    drive(1, 0, 1, '1, '0, 0, 1, 0, '1, NEXT, 1'b1, "R6 right write no byte enable");
    drive(0, 1, 0, 8'h00, NEXT - 1, 0, 1, 0, 8'h00, NEXT - 1, 1'b1, "R9 writes to other addr");
    drive(0, 1, 0, 8'h80, TOP, 0, 1, 1, '1, TOP, 1'b1, "R8 set beats clear");
    idle("R8 hold after tie");
    drive(1, 0, 1, '1, '0, 0, 1, 1, '1, TOP, 1'b1, "R3 clear after tie");
    drive(0, 1, 0, 8'h01, TOP, 0, 1, 0, 8'h01, NEXT, 1'b1, "R2 R4 both set");
    drive(0, 1, 0, 8'hFE, NEXT, 0, 1, 0, 8'hFE, TOP, 1'b1, "R9 own box writes");
    drive(1, 0, 1, '1, '0, 1, 0, 1, '1, '0, 1'b0, "R1 reset mid-run");
    idle("R1 after reset release");
    idle("R10 idle");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule